// File: doc/BRIEF.md
# GPIO Interrupt Line Router

This block sits between three GPIO controllers and a platform interrupt controller that has fewer inputs than the controllers have interrupts. Seventy GPIO interrupt signals arrive: 14 from controller A, 24 from controller B and 32 from controller C. They leave on 41 lines. Thirty-eight of these lines are exclusive, each carrying exactly one GPIO interrupt. Three are shared lines, each the OR of a group of interrupts.

A 32-bit selection register, reached through a small memory-mapped port, settles every contested pair. Each pair joins one line from controller A or B with one line from controller C. The interrupt that wins a pair takes the exclusive line. The one that loses is folded into the shared line of its own controller. Six controller B lines sit outside the register and always keep their own exclusive lines.

The block does no masking, latching, edge detection or prioritising. The outputs are a pure combinational function of the inputs and the register.

Top module: `gpio_irq_router`

## Requirements
- R1: After synchronous reset the selection register is 0, and a read at offset 0x54 returns 0.
- R2: A write with `wr_en` high and `addr` = 0x54 loads all 32 bits of `wdata` at the next clock edge. `rdata` is registered: it shows the register one cycle after `addr` = 0x54 is presented.
- R3: For bit n in 0..13, `excl_irq[n]` carries controller A line n when the bit is 0, and controller C line n when it is 1.
- R4: For bit n in 14..31, `excl_irq[n]` carries controller B line n-14 when the bit is 0, and controller C line n when it is 1.
- R5: `excl_irq[32+k]` for k in 0..5 always carries controller B line 18+k, whatever the register holds.
- R6: Each shared output collects the losing lines of one controller:
  - `shared_irq[0]` is the OR of controller A line n over the bits n (0..13) that are 1.
  - `shared_irq[1]` is the OR of controller B line n-14 over the bits n (14..31) that are 1.
  - `shared_irq[2]` is the OR of controller C line n over the bits n that are 0.
- R7: Any offset other than 0x54 reads as 0, and writes to it leave the register unchanged.
- R8: Routing is combinational. An input change shows on the outputs in the same cycle, using the register value that held before the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| gpio_a_irq | input | 14 | Controller A interrupts |
| gpio_b_irq | input | 24 | Controller B interrupts |
| gpio_c_irq | input | 32 | Controller C interrupts |
| excl_irq | output | 38 | Exclusive lines; bits 0..31 are paired, bits 32..37 are fixed |
| shared_irq | output | 3 | Shared lines for controllers A, B and C |

## Verification
A register write and a change of GPIO inputs can fall in the same cycle. In that cycle the new input pattern must be routed using the old selection, and only after the edge using the new selection. The bench provokes this by driving a write and fresh interrupt values together at one falling edge. It checks every exclusive and shared output just after the drive, against the old selection model. It checks them again one cycle later, against the updated model.

// File: rtl/gir_pkg.sv
package gir_pkg;
  localparam int unsigned GIR_A_LINES  = 14;
  localparam int unsigned GIR_B_LINES  = 24;
  localparam int unsigned GIR_C_LINES  = 32;
  localparam int unsigned GIR_ADDR_W   = 8;
  localparam int unsigned GIR_SEL_OFFS = 'h54;

  // Which side of a contested pair owns the exclusive line
  typedef enum logic {
    OWNER_LOW  = 1'b0,
    OWNER_HIGH = 1'b1
  } owner_e;
endpackage

// File: rtl/gir_sel_reg.sv
module gir_sel_reg #(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned OFFS   = 'h54
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  output logic [W-1:0]      sel
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(OFFS);

  logic hit;
  assign hit = (addr == HIT_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel   <= '0;
      rdata <= '0;
    end else begin
      if (wr_en && hit) sel <= wdata;
      rdata <= hit ? sel : '0;
    end
  end

  // R2: a write at the selection offset lands one edge later
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && hit && !rst) |-> (sel == $past(wdata)));

  // R7: writes elsewhere leave the selection untouched
  p_ignore_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !hit) |=> $stable(sel));

  // R7: reads elsewhere return zero
  p_rd_zero_r7: assert property (@(posedge clk) disable iff (rst)
    $past(!hit && !rst) |-> (rdata == '0));
endmodule

// File: rtl/gir_pair_route.sv
module gir_pair_route
  import gir_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic low_irq,
  input  logic high_irq,
  output logic excl_o,
  output logic low_sh_o,
  output logic high_sh_o
);
  owner_e owner;
  assign owner = owner_e'(sel);

  always_comb begin
    excl_o    = 1'b0;
    low_sh_o  = 1'b0;
    high_sh_o = 1'b0;
    unique case (owner)
      OWNER_LOW: begin
        excl_o    = low_irq;
        high_sh_o = high_irq;
      end
      OWNER_HIGH: begin
        excl_o   = high_irq;
        low_sh_o = low_irq;
      end
      default: ;
    endcase
  end

  // R3: an active low-side interrupt always reaches some output
  p_low_routed_r3: assert property (@(posedge clk) disable iff (rst)
    low_irq |-> (excl_o || low_sh_o));

  // R4: an active high-side interrupt always reaches some output
  p_high_routed_r4: assert property (@(posedge clk) disable iff (rst)
    high_irq |-> (excl_o || high_sh_o));

  // R6: at most one side of a pair is demoted to sharing
  p_one_demoted_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({low_sh_o, high_sh_o}));
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gir_pkg::*;
#(
  parameter int unsigned A_LINES = GIR_A_LINES,
  parameter int unsigned B_LINES = GIR_B_LINES,
  parameter int unsigned C_LINES = GIR_C_LINES,
  parameter int unsigned ADDR_W  = GIR_ADDR_W,
  parameter int unsigned SEL_OFFS = GIR_SEL_OFFS,
  localparam int unsigned B_MUXED = C_LINES - A_LINES,
  localparam int unsigned B_FIXED = B_LINES - B_MUXED,
  localparam int unsigned EXCL_N  = C_LINES + B_FIXED
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [C_LINES-1:0] wdata,
  output logic [C_LINES-1:0] rdata,
  input  logic [A_LINES-1:0] gpio_a_irq,
  input  logic [B_LINES-1:0] gpio_b_irq,
  input  logic [C_LINES-1:0] gpio_c_irq,
  output logic [EXCL_N-1:0]  excl_irq,
  output logic [2:0]         shared_irq
);
  logic [C_LINES-1:0] sel;
  logic [A_LINES-1:0] a_sh;
  logic [B_MUXED-1:0] b_sh;
  logic [C_LINES-1:0] c_sh;

  gir_sel_reg #(.W(C_LINES), .ADDR_W(ADDR_W), .OFFS(SEL_OFFS)) u_sel (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sel(sel)
  );

  for (genvar n = 0; n < C_LINES; n++) begin : g_pair
    logic low_in;
    logic low_sh;

    if (n < A_LINES) begin : g_from_a
      assign low_in  = gpio_a_irq[n];
      assign a_sh[n] = low_sh;
    end else begin : g_from_b
      assign low_in          = gpio_b_irq[n-A_LINES];
      assign b_sh[n-A_LINES] = low_sh;
    end

    gir_pair_route u_route (
      .clk(clk), .rst(rst), .sel(sel[n]),
      .low_irq(low_in), .high_irq(gpio_c_irq[n]),
      .excl_o(excl_irq[n]), .low_sh_o(low_sh), .high_sh_o(c_sh[n])
    );
  end

  for (genvar k = 0; k < B_FIXED; k++) begin : g_fixed
    assign excl_irq[C_LINES+k] = gpio_b_irq[B_MUXED+k];
  end

  assign shared_irq[0] = |a_sh;
  assign shared_irq[1] = |b_sh;
  assign shared_irq[2] = |c_sh;

  // R6: with A and B owning every pair, their shared lines stay low
  p_ab_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (sel == '0) |-> (shared_irq[1:0] == 2'b00));

  // R6: with C owning every pair, its shared line stays low
  p_c_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (&sel) |-> !shared_irq[2]);

  // R5: the fixed B lines never depend on the register
  p_fixed_r5: assert property (@(posedge clk) disable iff (rst)
    $stable(gpio_b_irq) |-> $stable(excl_irq[EXCL_N-1:C_LINES]));
endmodule

// File: tb/gpio_irq_router_tb_top.sv
module gpio_irq_router_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] SEL_ADDR = 8'h54;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [13:0] ga = '0;
  logic [23:0] gb = '0;
  logic [31:0] gc = '0;
  logic [37:0] excl;
  logic [2:0]  shared;

  logic [31:0] m_sel = '0;
  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_router dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .gpio_a_irq(ga), .gpio_b_irq(gb), .gpio_c_irq(gc),
    .excl_irq(excl), .shared_irq(shared)
  );

  function automatic logic [37:0] exp_excl(input logic [31:0] s,
      input logic [13:0] a, input logic [23:0] b, input logic [31:0] c);
    logic [37:0] e;
    for (int n = 0; n < 32; n++) begin
      logic lo;
      lo = (n < 14) ? a[n] : b[n-14];
      e[n] = s[n] ? c[n] : lo;
    end
    for (int k = 0; k < 6; k++) e[32+k] = b[18+k];
    return e;
  endfunction

  function automatic logic [2:0] exp_shared(input logic [31:0] s,
      input logic [13:0] a, input logic [23:0] b, input logic [31:0] c);
    logic [2:0] r;
    r = '0;
    for (int n = 0; n < 32; n++) begin
      if (n < 14) r[0] = r[0] | (a[n] & s[n]);
      else        r[1] = r[1] | (b[n-14] & s[n]);
      r[2] = r[2] | (c[n] & ~s[n]);
    end
    return r;
  endfunction

  task automatic check_routes(input string tag);
    logic [37:0] ee;
    logic [2:0]  es;
    ee = exp_excl(m_sel, ga, gb, gc);
    es = exp_shared(m_sel, ga, gb, gc);
    tests++;
    if (excl !== ee) begin
      fails++;
      $display("FAIL %s excl act=%h exp=%h", tag, excl, ee);
    end
    tests++;
    if (shared !== es) begin
      fails++;
      $display("FAIL %s shared act=%b exp=%b", tag, shared, es);
    end
  endtask

  task automatic drive_irq(input logic [13:0] a, input logic [23:0] b,
                           input logic [31:0] c, input string tag);
    @(negedge clk);
    ga = a; gb = b; gc = c;
    #1 check_routes(tag);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == SEL_ADDR) m_sel = d;
  endtask

  task automatic read_check(input logic [7:0] a, input logic [31:0] e,
                            input string tag);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    tests++;
    if (rdata !== e) begin
      fails++;
      $display("FAIL %s rdata act=%h exp=%h", tag, rdata, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    read_check(SEL_ADDR, 32'h0, "R1");
    drive_irq(14'h3FFF, 24'hFFFFFF, 32'hFFFFFFFF, "R1");

    // R2: load and read back
    do_write(SEL_ADDR, 32'hA5A5_5A5A);
    read_check(SEL_ADDR, 32'hA5A5_5A5A, "R2");

    // R3: A versus C pairs
    do_write(SEL_ADDR, 32'h0000_0000);
    drive_irq(14'h2AAA, 24'h0, 32'h0000_1555, "R3");
    do_write(SEL_ADDR, 32'h0000_3FFF);
    drive_irq(14'h2AAA, 24'h0, 32'h0000_1555, "R3");

    // R4: B versus C pairs
    do_write(SEL_ADDR, 32'hFFFF_C000);
    drive_irq(14'h0, 24'h02_AAAA, 32'h5555_0000, "R4");
    do_write(SEL_ADDR, 32'h0000_0000);
    drive_irq(14'h0, 24'h02_AAAA, 32'h5555_0000, "R4");

    // R5: fixed B lines under both extreme selections
    drive_irq(14'h0, 24'hA5_0000, 32'h0, "R5");
    do_write(SEL_ADDR, 32'hFFFF_FFFF);
    drive_irq(14'h0, 24'h5A_0000, 32'hFFFF_FFFF, "R5");

    // R6: single demoted lines raise only their own shared output
    do_write(SEL_ADDR, 32'h0000_2000);
    drive_irq(14'h2000, 24'h0, 32'h0, "R6");
    do_write(SEL_ADDR, 32'h8000_0000);
    drive_irq(14'h0, 24'h02_0000, 32'h0, "R6");
    do_write(SEL_ADDR, 32'hFFFF_FFFE);
    drive_irq(14'h0, 24'h0, 32'h0000_0001, "R6");

    // R7: other offsets ignored on write, zero on read
    do_write(SEL_ADDR, 32'h1234_5678);
    do_write(8'h50, 32'hDEAD_BEEF);
    do_write(8'h58, 32'hCAFE_F00D);
    read_check(SEL_ADDR, 32'h1234_5678, "R7");
    read_check(8'h50, 32'h0, "R7");
    drive_irq(14'h1234, 24'h65_4321, 32'h0F0F_F0F0, "R7");

    // R8: write and input change in the same cycle
    @(negedge clk);
    wr_en = 1'b1; addr = SEL_ADDR; wdata = 32'h0F0F_0F0F;
    ga = 14'h3C3C; gb = 24'hC3_C3C3; gc = 32'h3333_CCCC;
    #1 check_routes("R8");
    @(negedge clk);
    wr_en = 1'b0;
    m_sel = 32'h0F0F_0F0F;
    #1 check_routes("R8");

    // Random mix across R3, R4, R5, R6
    for (int i = 0; i < 200; i++) begin
      if (($urandom % 3) == 0) do_write(SEL_ADDR, $urandom);
      drive_irq(14'($urandom), 24'($urandom), $urandom, "R3/R4/R5/R6 rnd");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule